// File: doc/BRIEF.md
# Memory Dependence Wakeup Scheduler

This block holds in-flight loads and stores between dispatch and issue. Each held entry carries two readiness flags: one for its register operands and one for its memory dependence. An entry moves to the ready set only when both flags are set. When an external predictor names an older store as the likely producer of an entry's data, the entry is linked to that store. It is woken only after that store has issued. Non-speculative memory operations bypass both flags and wait for an explicit release.

The issue side pops the oldest ready entry, ranked by sequence number. When a popped store has dependents, they are woken in the same cycle. A squash removes every entry younger than a given sequence number, together with any link from a surviving store to a removed dependent. Store inserts, issues, squashes and ordering violations are passed on to the external predictor in the cycle they happen. The predictor's own tables lie outside this block.

Top module: `memdep_wakeup_sched`

## Requirements
- R1: After reset the unit is empty: `pop_valid_o` is 0, `in_ready_o` is 1 and `err_o` is 0.
- R2: An entry inserted with `in_ops_rdy_i`=1 and no dependence can be popped from the next cycle. An entry inserted with operands not ready is held until a registers-ready notice carries its sequence number, and is poppable the cycle after that notice.
- R3: Whether an entry has a dependence depends on `in_prod_seq_i`. When it is nonzero and equals the sequence number of a store that is held and not yet issued, the entry waits until that store is popped. This holds even if its operands were ready at insert; in that case the entry is poppable the cycle after the store's pop. When `in_prod_seq_i` is 0, or names no held store, the entry has no dependence.
- R4: A dependent entry with operands not ready stays held after its store issues. It is released by a later registers-ready notice. A registers-ready notice that arrives before the store issues is remembered, so the entry becomes ready when the store pops.
- R5: A non-speculative entry (`in_nonspec_i`=1) becomes ready only on a release notice carrying its sequence number. Registers-ready notices and `in_ops_rdy_i` have no effect on it.
- R6: `pop_seq_o`, `pop_pc_o` and `pop_store_o` always show the ready entry with the lowest sequence number. A pop (`pop_i` high while `pop_valid_o` is high) removes that entry.
- R7: A pop raises `pred_iss_valid_o` in the same cycle. The predictor reads the issued entry's PC, sequence number and store flag from `pop_pc_o`, `pop_seq_o` and `pop_store_o`.
- R8: An accepted store insert raises `pred_ins_valid_o` in the same cycle, with the store's sequence number on `pred_ins_seq_o` and its PC on `pred_ins_pc_o`. A load insert does not raise it.
- R9: A squash removes every held entry whose sequence number is greater than `squash_seq_i`. It also clears the links from surviving stores to removed entries, so that a slot reused later is never woken by a stale link. `pred_sq_valid_o` and `pred_sq_seq_o` forward the squash in the same cycle. In a squash cycle, `in_ready_o` and `pop_valid_o` are 0.
- R10: A violation notice is forwarded in the same cycle. The load PC appears on `pred_viol_load_pc_o` and the store PC on `pred_viol_store_pc_o`.
- R11: With all `DEPTH` slots held, `in_ready_o` is 0 and an insert attempt is ignored. `in_ready_o` returns to 1 in the cycle after a pop.
- R12: `in_kind_i` encodes 2'b01 as a load and 2'b10 as a store. An insert with either other code is not accepted and sets `err_o`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Insert request |
| in_ready_o | output | 1 | Insert can be accepted |
| in_seq_i | input | SEQ_W | Sequence number of the inserted entry |
| in_pc_i | input | PC_W | PC of the inserted entry |
| in_kind_i | input | 2 | 01 load, 10 store, others illegal |
| in_nonspec_i | input | 1 | Entry waits for an explicit release |
| in_ops_rdy_i | input | 1 | Register operands ready at insert |
| in_prod_seq_i | input | SEQ_W | Predicted producer store, 0 for none |
| rn_valid_i | input | 1 | Registers-ready notice |
| rn_seq_i | input | SEQ_W | Entry whose operands became ready |
| rel_valid_i | input | 1 | Non-speculative release notice |
| rel_seq_i | input | SEQ_W | Entry being released |
| pop_valid_o | output | 1 | A ready entry is available |
| pop_i | input | 1 | Consume the shown entry |
| pop_seq_o | output | SEQ_W | Oldest ready sequence number |
| pop_pc_o | output | PC_W | PC of that entry |
| pop_store_o | output | 1 | That entry is a store |
| squash_valid_i | input | 1 | Squash request |
| squash_seq_i | input | SEQ_W | Entries younger than this are removed |
| viol_valid_i | input | 1 | Ordering violation notice |
| viol_load_pc_i | input | PC_W | PC of the violating load |
| viol_store_pc_i | input | PC_W | PC of the store it passed |
| pred_ins_valid_o | output | 1 | Store inserted, to predictor |
| pred_ins_seq_o | output | SEQ_W | Inserted store sequence number |
| pred_ins_pc_o | output | PC_W | Inserted store PC |
| pred_iss_valid_o | output | 1 | Entry issued, to predictor |
| pred_sq_valid_o | output | 1 | Squash, to predictor |
| pred_sq_seq_o | output | SEQ_W | Squash sequence number |
| pred_viol_valid_o | output | 1 | Violation, to predictor |
| pred_viol_load_pc_o | output | PC_W | Violating load PC |
| pred_viol_store_pc_o | output | PC_W | Violated store PC |
| err_o | output | 1 | Sticky illegal-kind error |

## Verification
The assertions rely on sequence numbers that are unique among held entries and increase with age without wrapping. They also rely on notices that name only entries currently held. Every directed scenario in the bench issues unique, monotonic sequence numbers and refers only to entries it has inserted and not yet popped or squashed. It also never raises a squash together with other requests, except to show that those requests are blocked.

// File: rtl/memdep_pkg.sv
package memdep_pkg;
  typedef enum logic [1:0] {
    KIND_BAD_LO = 2'b00,
    KIND_LOAD   = 2'b01,
    KIND_STORE  = 2'b10,
    KIND_BAD_HI = 2'b11
  } mem_kind_e;
endpackage

// File: rtl/memdep_seq_match.sv
module memdep_seq_match #(
  parameter int DEPTH = 16,
  parameter int SEQ_W = 16
) (
  input  logic [DEPTH-1:0]            mask_i,
  input  logic [DEPTH-1:0][SEQ_W-1:0] seq_i,
  input  logic [SEQ_W-1:0]            key_i,
  output logic [DEPTH-1:0]            hit_o
);
  always_comb begin
    for (int i = 0; i < DEPTH; i++) hit_o[i] = mask_i[i] && (seq_i[i] == key_i);
  end
endmodule

// File: rtl/memdep_free_pick.sv
module memdep_free_pick #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] free_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (free_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/memdep_oldest_pick.sv
module memdep_oldest_pick #(
  parameter int DEPTH = 16,
  parameter int SEQ_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]            req_i,
  input  logic [DEPTH-1:0][SEQ_W-1:0] seq_i,
  output logic                        any_o,
  output logic [IDX_W-1:0]            idx_o
);
  logic [SEQ_W-1:0] best;
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    best  = '1;
    for (int i = 0; i < DEPTH; i++) begin
      if (req_i[i] && (!any_o || seq_i[i] < best)) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
        best  = seq_i[i];
      end
    end
  end
endmodule

// File: rtl/memdep_wakeup_sched.sv
module memdep_wakeup_sched
  import memdep_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [SEQ_W-1:0] in_seq_i,
  input  logic [PC_W-1:0]  in_pc_i,
  input  logic [1:0]       in_kind_i,
  input  logic             in_nonspec_i,
  input  logic             in_ops_rdy_i,
  input  logic [SEQ_W-1:0] in_prod_seq_i,
  input  logic             rn_valid_i,
  input  logic [SEQ_W-1:0] rn_seq_i,
  input  logic             rel_valid_i,
  input  logic [SEQ_W-1:0] rel_seq_i,
  output logic             pop_valid_o,
  input  logic             pop_i,
  output logic [SEQ_W-1:0] pop_seq_o,
  output logic [PC_W-1:0]  pop_pc_o,
  output logic             pop_store_o,
  input  logic             squash_valid_i,
  input  logic [SEQ_W-1:0] squash_seq_i,
  input  logic             viol_valid_i,
  input  logic [PC_W-1:0]  viol_load_pc_i,
  input  logic [PC_W-1:0]  viol_store_pc_i,
  output logic             pred_ins_valid_o,
  output logic [SEQ_W-1:0] pred_ins_seq_o,
  output logic [PC_W-1:0]  pred_ins_pc_o,
  output logic             pred_iss_valid_o,
  output logic             pred_sq_valid_o,
  output logic [SEQ_W-1:0] pred_sq_seq_o,
  output logic             pred_viol_valid_o,
  output logic [PC_W-1:0]  pred_viol_load_pc_o,
  output logic [PC_W-1:0]  pred_viol_store_pc_o,
  output logic             err_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int N_CAM = 3;  // 0 producer, 1 regs notice, 2 release

  logic [DEPTH-1:0]            vld_q, rdy_q, regs_q, mem_q, nsp_q, st_q;
  logic [DEPTH-1:0][SEQ_W-1:0] seq_q;
  logic [DEPTH-1:0][PC_W-1:0]  pc_q;
  logic [DEPTH-1:0][DEPTH-1:0] dep_q;  // dep_q[s][d]: slot d waits on store in slot s
  logic                        err_q;

  logic [N_CAM-1:0][DEPTH-1:0] cam_mask, cam_hit;
  logic [N_CAM-1:0][SEQ_W-1:0] cam_key;

  logic             pop_any, free_any, pop_fire, ins_fire, kind_ok, is_store, has_dep;
  logic [IDX_W-1:0] pop_idx, free_idx;
  logic [DEPTH-1:0] pop_oh, free_oh, kill, wake, prod_hit, rn_hit, rel_hit;

  memdep_oldest_pick #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_oldest (
    .req_i(vld_q & rdy_q), .seq_i(seq_q), .any_o(pop_any), .idx_o(pop_idx)
  );

  memdep_free_pick #(.DEPTH(DEPTH)) u_free (
    .free_i(~vld_q), .any_o(free_any), .idx_o(free_idx)
  );

  always_comb begin
    cam_mask[0] = vld_q & st_q & ~pop_oh;
    cam_key[0]  = in_prod_seq_i;
    cam_mask[1] = rn_valid_i ? (vld_q & ~rdy_q) : '0;
    cam_key[1]  = rn_seq_i;
    cam_mask[2] = rel_valid_i ? (vld_q & ~rdy_q & nsp_q) : '0;
    cam_key[2]  = rel_seq_i;
  end

  for (genvar c = 0; c < N_CAM; c++) begin : g_cam
    memdep_seq_match #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_match (
      .mask_i(cam_mask[c]), .seq_i(seq_q), .key_i(cam_key[c]), .hit_o(cam_hit[c])
    );
  end

  assign prod_hit = cam_hit[0];
  assign rn_hit   = cam_hit[1];
  assign rel_hit  = cam_hit[2];

  assign kind_ok  = (in_kind_i == KIND_LOAD) || (in_kind_i == KIND_STORE);
  assign is_store = (in_kind_i == KIND_STORE);

  assign in_ready_o  = free_any && !squash_valid_i;
  assign ins_fire    = in_valid_i && in_ready_o && kind_ok;
  assign has_dep     = !in_nonspec_i && (in_prod_seq_i != '0) && (|prod_hit);

  assign pop_valid_o = pop_any && !squash_valid_i;
  assign pop_fire    = pop_valid_o && pop_i;
  assign pop_seq_o   = seq_q[pop_idx];
  assign pop_pc_o    = pc_q[pop_idx];
  assign pop_store_o = st_q[pop_idx];

  always_comb begin
    pop_oh  = '0;
    free_oh = '0;
    if (pop_fire) pop_oh[pop_idx] = 1'b1;
    if (ins_fire) free_oh[free_idx] = 1'b1;
    wake = (pop_fire && st_q[pop_idx]) ? dep_q[pop_idx] : '0;
    for (int i = 0; i < DEPTH; i++)
      kill[i] = squash_valid_i && vld_q[i] && (seq_q[i] > squash_seq_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      rdy_q  <= '0;
      regs_q <= '0;
      mem_q  <= '0;
      nsp_q  <= '0;
      st_q   <= '0;
      seq_q  <= '0;
      pc_q   <= '0;
      dep_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      if (in_valid_i && in_ready_o && !kind_ok) err_q <= 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
        if (kill[i] || pop_oh[i]) begin
          vld_q[i] <= 1'b0;
          rdy_q[i] <= 1'b0;
          dep_q[i] <= '0;
        end else if (free_oh[i]) begin
          vld_q[i]  <= 1'b1;
          seq_q[i]  <= in_seq_i;
          pc_q[i]   <= in_pc_i;
          st_q[i]   <= is_store;
          nsp_q[i]  <= in_nonspec_i;
          regs_q[i] <= in_ops_rdy_i && !in_nonspec_i;
          mem_q[i]  <= !has_dep && !in_nonspec_i;
          rdy_q[i]  <= in_ops_rdy_i && !has_dep && !in_nonspec_i;
          dep_q[i]  <= '0;
        end else begin
          if (vld_q[i] && !rdy_q[i]) begin
            regs_q[i] <= regs_q[i] | rn_hit[i];
            mem_q[i]  <= mem_q[i] | wake[i];
            rdy_q[i]  <= nsp_q[i] ? rel_hit[i]
                                  : ((regs_q[i] | rn_hit[i]) & (mem_q[i] | wake[i]));
          end
          dep_q[i] <= (dep_q[i] & ~kill)
                    | ((has_dep && prod_hit[i]) ? free_oh : '0);
        end
      end
    end
  end

  assign err_o                = err_q;
  assign pred_ins_valid_o     = ins_fire && is_store;
  assign pred_ins_seq_o       = in_seq_i;
  assign pred_ins_pc_o        = in_pc_i;
  assign pred_iss_valid_o     = pop_fire;
  assign pred_sq_valid_o      = squash_valid_i;
  assign pred_sq_seq_o        = squash_seq_i;
  assign pred_viol_valid_o    = viol_valid_i;
  assign pred_viol_load_pc_o  = viol_load_pc_i;
  assign pred_viol_store_pc_o = viol_store_pc_i;

  // Independent age check against the selector output
  logic older_ready;
  always_comb begin
    older_ready = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (vld_q[i] && rdy_q[i] && seq_q[i] < pop_seq_o) older_ready = 1'b1;
  end

  assert_pop_oldest_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_valid_o |-> !older_ready);

  assert_full_block_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&vld_q) |-> !in_ready_o);

  assert_err_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  for (genvar g = 0; g < DEPTH; g++) begin : g_chk
    assert_squash_removes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (squash_valid_i && vld_q[g] && seq_q[g] > squash_seq_i) |=> !vld_q[g]);

    assert_nonspec_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_q[g] && nsp_q[g] && !rdy_q[g] && !rel_hit[g]) |=> !rdy_q[g]);

    assert_dep_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_q[g] && !nsp_q[g] && !rdy_q[g] && !mem_q[g] && !wake[g]) |=> !rdy_q[g]);
  end
endmodule

// File: tb/memdep_wakeup_sched_tb.sv
module memdep_wakeup_sched_tb_top;
  localparam int DEPTH = 16;
  localparam int SEQ_W = 16;
  localparam int PC_W  = 32;
  localparam logic [1:0] LD = 2'b01;
  localparam logic [1:0] ST = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             in_valid, in_ready, in_nsp, in_ops, rn_valid, rel_valid, pop_valid, pop_req;
  logic [SEQ_W-1:0] in_seq, in_prod, rn_seq, rel_seq, pop_seq, sq_seq, p_ins_seq, p_sq_seq;
  logic [PC_W-1:0]  in_pc, pop_pc, v_lpc, v_spc, p_ins_pc, p_v_lpc, p_v_spc;
  logic [1:0]       in_kind;
  logic             pop_st, sq_valid, v_valid, p_ins_v, p_iss_v, p_sq_v, p_v_v, err;

  int checks = 0;
  int errors = 0;

  memdep_wakeup_sched #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .PC_W(PC_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_seq_i(in_seq), .in_pc_i(in_pc),
    .in_kind_i(in_kind), .in_nonspec_i(in_nsp), .in_ops_rdy_i(in_ops), .in_prod_seq_i(in_prod),
    .rn_valid_i(rn_valid), .rn_seq_i(rn_seq), .rel_valid_i(rel_valid), .rel_seq_i(rel_seq),
    .pop_valid_o(pop_valid), .pop_i(pop_req), .pop_seq_o(pop_seq), .pop_pc_o(pop_pc),
    .pop_store_o(pop_st), .squash_valid_i(sq_valid), .squash_seq_i(sq_seq),
    .viol_valid_i(v_valid), .viol_load_pc_i(v_lpc), .viol_store_pc_i(v_spc),
    .pred_ins_valid_o(p_ins_v), .pred_ins_seq_o(p_ins_seq), .pred_ins_pc_o(p_ins_pc),
    .pred_iss_valid_o(p_iss_v), .pred_sq_valid_o(p_sq_v), .pred_sq_seq_o(p_sq_seq),
    .pred_viol_valid_o(p_v_v), .pred_viol_load_pc_o(p_v_lpc), .pred_viol_store_pc_o(p_v_spc),
    .err_o(err)
  );

  function automatic logic [PC_W-1:0] pc_of(input int s);
    return PC_W'(32'h1000 + s * 4);
  endfunction

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic idle();
    in_valid = 0; in_seq = '0; in_pc = '0; in_kind = LD; in_nsp = 0; in_ops = 0; in_prod = '0;
    rn_valid = 0; rn_seq = '0; rel_valid = 0; rel_seq = '0; pop_req = 0;
    sq_valid = 0; sq_seq = '0; v_valid = 0; v_lpc = '0; v_spc = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
  endtask

  task automatic ins(input int s, input logic [1:0] k, input logic nsp, input logic ops, input int prod);
    in_valid = 1; in_seq = SEQ_W'(s); in_pc = pc_of(s); in_kind = k;
    in_nsp = nsp; in_ops = ops; in_prod = SEQ_W'(prod);
    tick();
  endtask

  task automatic notify(input int s);
    rn_valid = 1; rn_seq = SEQ_W'(s);
    tick();
  endtask

  task automatic pop_exp(input int s, input logic st, input string tag);
    pop_req = 1; #1;
    chk({tag, " pop_valid"}, 64'(pop_valid), 64'd1);
    chk({tag, " pop_seq"}, 64'(pop_seq), 64'(s));
    chk({tag, " pop_pc"}, 64'(pop_pc), 64'(pc_of(s)));
    chk({tag, " pop_store"}, 64'(pop_st), 64'(st));
    chk({tag, " R7 pred_iss_valid"}, 64'(p_iss_v), 64'd1);
    tick();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 pop_valid", 64'(pop_valid), 0);
    chk("R1 in_ready", 64'(in_ready), 1);
    chk("R1 err", 64'(err), 0);
  endtask

  task automatic t_nodep();
    do_reset();
    ins(10, LD, 0, 1, 0);
    ins(11, LD, 0, 0, 5);  // producer 5 not held: no dependence
    pop_exp(10, 0, "R2 ready load");
    chk("R2 waiting load held", 64'(pop_valid), 0);
    notify(11);
    pop_exp(11, 0, "R2/R3 unmatched producer after notice");
  endtask

  task automatic t_dep();
    do_reset();
    in_valid = 1; in_seq = 20; in_pc = pc_of(20); in_kind = ST; in_ops = 0; #1;
    chk("R8 pred_ins_valid", 64'(p_ins_v), 1);
    chk("R8 pred_ins_seq", 64'(p_ins_seq), 20);
    chk("R8 pred_ins_pc", 64'(p_ins_pc), 64'(pc_of(20)));
    tick();
    in_valid = 1; in_seq = 21; in_pc = pc_of(21); in_kind = LD; in_ops = 1; in_prod = 20; #1;
    chk("R8 load not reported", 64'(p_ins_v), 0);
    tick();
    chk("R3 dependent held", 64'(pop_valid), 0);
    notify(20);
    pop_exp(20, 1, "R3 store");
    pop_exp(21, 0, "R3 woken dependent");
  endtask

  task automatic t_dep_regs();
    do_reset();
    ins(30, ST, 0, 0, 0);
    ins(31, LD, 0, 0, 30);
    ins(32, LD, 0, 0, 30);
    notify(31);
    chk("R4 early notice does not release", 64'(pop_valid), 0);
    notify(30);
    pop_exp(30, 1, "R4 store");
    pop_exp(31, 0, "R4 early-notified dependent");
    chk("R4 dependent without regs held", 64'(pop_valid), 0);
    notify(32);
    pop_exp(32, 0, "R4 late notice");
  endtask

  task automatic t_nonspec();
    do_reset();
    ins(40, LD, 1, 1, 0);
    chk("R5 nonspec held", 64'(pop_valid), 0);
    notify(40);
    chk("R5 regs notice no effect", 64'(pop_valid), 0);
    rel_valid = 1; rel_seq = 40;
    tick();
    pop_exp(40, 0, "R5 released");
  endtask

  task automatic t_order();
    do_reset();
    ins(55, LD, 0, 1, 0);
    ins(52, ST, 0, 1, 0);
    ins(58, LD, 0, 1, 0);
    pop_exp(52, 1, "R6 first");
    pop_exp(55, 0, "R6 second");
    pop_exp(58, 0, "R6 third");
    chk("R6 empty", 64'(pop_valid), 0);
  endtask

  task automatic t_squash();
    do_reset();
    ins(60, ST, 0, 0, 0);  // slot 0
    ins(61, ST, 0, 0, 0);  // slot 1
    ins(62, LD, 0, 1, 60); // slot 2, linked to 60
    ins(59, LD, 0, 1, 0);  // slot 3, older than squash point, ready
    sq_valid = 1; sq_seq = 61; in_valid = 1; in_seq = 70; in_kind = LD; in_ops = 1; #1;
    chk("R9 in_ready low", 64'(in_ready), 0);
    chk("R9 pop_valid low", 64'(pop_valid), 0);
    chk("R9 pred_sq_valid", 64'(p_sq_v), 1);
    chk("R9 pred_sq_seq", 64'(p_sq_seq), 61);
    tick();
    pop_exp(59, 0, "R9 survivor");
    chk("R9 blocked insert absent", 64'(pop_valid), 0);
    ins(63, LD, 0, 1, 61); // reuses slot 2, linked to 61
    notify(60);
    pop_exp(60, 1, "R9 store 60");
    chk("R9 stale link ignored", 64'(pop_valid), 0);
    notify(61);
    pop_exp(61, 1, "R9 store 61");
    pop_exp(63, 0, "R9 reused slot woken");
  endtask

  task automatic t_viol();
    do_reset();
    v_valid = 1; v_lpc = 32'hABCD_0010; v_spc = 32'h1234_0020; #1;
    chk("R10 valid", 64'(p_v_v), 1);
    chk("R10 load pc", 64'(p_v_lpc), 64'h ABCD0010);
    chk("R10 store pc", 64'(p_v_spc), 64'h12340020);
    tick();
    chk("R10 idle", 64'(p_v_v), 0);
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < DEPTH; i++) ins(100 + i, LD, 0, 0, 0);
    chk("R11 in_ready low when full", 64'(in_ready), 0);
    ins(99, LD, 0, 1, 0);
    chk("R11 insert while full ignored", 64'(pop_valid), 0);
    notify(100);
    pop_exp(100, 0, "R11 pop");
    chk("R11 in_ready back", 64'(in_ready), 1);
  endtask

  task automatic t_err();
    do_reset();
    ins(5, 2'b11, 0, 1, 0);
    chk("R12 err set", 64'(err), 1);
    chk("R12 not accepted", 64'(pop_valid), 0);
    ins(6, 2'b00, 0, 1, 0);
    ins(7, LD, 0, 1, 0);
    pop_exp(7, 0, "R12 normal after error");
    chk("R12 err sticky", 64'(err), 1);
  endtask

  initial begin
    idle();
    t_reset();
    t_nodep();
    t_dep();
    t_dep_regs();
    t_nonspec();
    t_order();
    t_squash();
    t_viol();
    t_full();
    t_err();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule